// File: doc/BRIEF.md
# Caller ID Frame Checker

This block sits behind a preamble detector and a bit-level receiver in a caller identification path. Once the preamble detector raises its start enable, the block reads the character stream that follows. It passes over any fill characters, confirms that the message is a calling-number delivery message, and takes the length byte. It then counts that many data words and presents each one with its position. The byte after the last data word is the closing checksum, and the block verifies it against a modulo-256 running sum.

Each attempt ends in exactly one pulse. The good pulse means the whole frame, checksum included, sums to zero modulo 256. The error pulse means a wrong message type, a length out of range or a failed sum. The timeout pulse means the line went quiet for too long while a byte was awaited. After any of these pulses the block ignores the line until the next start enable. The first eight data words carry the date and time digits, and the words after them carry the number or a single letter. The block forwards all of them unchanged and leaves their meaning to the consumer.

Top module: `cid_frame_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is low, and the block waits for a start enable.
- R2: A byte that arrives while the block is idle has no effect: no payload strobe and no pulse. Idle means before the first start enable, or after a frame has ended in a good, error or timeout pulse. A start enable restarts parsing at any point, drops the partial frame silently, and takes priority over a byte in the same cycle.
- R3: Before the message type, bytes equal to 0x55 are skipped. A type byte of 0x04 is accepted. Any other value raises the error pulse one cycle later and ends the frame.
- R4: The byte after the type is the data word count, an unsigned binary value. Values 9 to 18 are accepted. Any other value raises the error pulse one cycle later and ends the frame.
- R5: Exactly as many data bytes as the count are forwarded. Each appears on the payload outputs one cycle after it arrives, with an index that runs 0, 1, ... up to count-1. Inside the data field a 0x55 byte counts as data.
- R6: The byte after the last data word is the checksum. The good pulse is raised when type + count + all data bytes + checksum equals 0 modulo 256. Otherwise the error pulse is raised.
- R7: While the block is active, TMO_MS millisecond ticks with no byte raise the timeout pulse and end the frame. Every byte restarts the count, and a byte and a tick in the same cycle count as a byte.
- R8: The good, error and timeout pulses last one cycle each, and at most one of them is high in any cycle.
- R9: The good or error pulse for the checksum appears exactly one cycle after the checksum byte is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start enable from the preamble detector |
| byte_vld_i | input | 1 | Received character strobe |
| byte_i | input | 8 | Received character |
| ms_tick_i | input | 1 | One-cycle millisecond tick for the idle timer |
| pay_vld_o | output | 1 | Payload byte strobe |
| pay_byte_o | output | 8 | Payload byte |
| pay_idx_o | output | 8 | Position of the payload byte in the data field |
| msg_ok_o | output | 1 | Frame accepted pulse |
| msg_err_o | output | 1 | Frame rejected pulse |
| msg_tmo_o | output | 1 | Idle timeout pulse |

## Verification
A corrupted running sum shows only at the frame's end, as a swapped good or error pulse one cycle after the checksum byte. The bench therefore drives frames with correct checksums and with checksums off by a random nonzero amount. A wrong word counter shows within one byte of the expected end: the count of forwarded bytes is too high or too low, or the index jumps or is repeated. A wrong parser state or timer state shows as a pulse that is missing or arrives at the wrong time, or as payload forwarded while idle. The tests for a one-tick-short gap, for a tick in the same cycle as a byte, and for bytes sent after a frame ends expose these faults within a few cycles.

// File: rtl/cid_pkg.sv
package cid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HUNT = 3'd1,
        ST_LEN  = 3'd2,
        ST_DATA = 3'd3,
        ST_CSUM = 3'd4
    } state_e;

    typedef struct packed {
        state_e     st;
        logic [7:0] sum;
        logic [7:0] remain;
        logic [7:0] idx;
        logic       pay_vld;
        logic [7:0] pay_byte;
        logic [7:0] pay_idx;
        logic       ok;
        logic       err;
        logic       tmo;
    } ctx_t;

endpackage

// File: rtl/cid_byte_class.sv
module cid_byte_class #(
    parameter logic [7:0] FILL_CODE = 8'h55,
    parameter logic [7:0] TYPE_CODE = 8'h04,
    parameter int unsigned LEN_MIN  = 9,
    parameter int unsigned LEN_MAX  = 18
) (
    input  logic [7:0] byte_i,
    output logic       is_fill_o,
    output logic       is_type_o,
    output logic       len_ok_o
);
    localparam logic [7:0] LO = 8'(LEN_MIN);
    localparam logic [7:0] HI = 8'(LEN_MAX);

    always_comb begin
        is_fill_o = (byte_i == FILL_CODE);
        is_type_o = (byte_i == TYPE_CODE);
        len_ok_o  = (byte_i >= LO) && (byte_i <= HI);
    end
endmodule

// File: rtl/cid_sum8.sv
module cid_sum8 #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] sum_o,
    output logic         zero_o
);
    always_comb begin
        sum_o  = acc_i + add_i;
        zero_o = (sum_o == '0);
    end
endmodule

// File: rtl/cid_watchdog.sv
module cid_watchdog #(
    parameter int unsigned TMO_MS = 700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int unsigned CW = (TMO_MS < 2) ? 1 : $clog2(TMO_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_MS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && !kick_i && tick_i && (cnt_q == LAST);
        cnt_d    = cnt_q;
        if (!run_i || kick_i || expire_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cid_frame_checker.sv
module cid_frame_checker #(
    parameter logic [7:0]  FILL_CODE = 8'h55,
    parameter logic [7:0]  TYPE_CODE = 8'h04,
    parameter int unsigned LEN_MIN   = 9,
    parameter int unsigned LEN_MAX   = 18,
    parameter int unsigned TMO_MS    = 700
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       ms_tick_i,
    output logic       pay_vld_o,
    output logic [7:0] pay_byte_o,
    output logic [7:0] pay_idx_o,
    output logic       msg_ok_o,
    output logic       msg_err_o,
    output logic       msg_tmo_o
);
    import cid_pkg::*;

    ctx_t   ctx_d, ctx_q;
    state_e st_q;
    logic   is_fill, is_type, len_ok;
    logic [7:0] sum_nxt;
    logic   sum_zero;
    logic   expire;

    assign st_q = ctx_q.st;

    cid_byte_class #(
        .FILL_CODE (FILL_CODE),
        .TYPE_CODE (TYPE_CODE),
        .LEN_MIN   (LEN_MIN),
        .LEN_MAX   (LEN_MAX)
    ) u_class (
        .byte_i    (byte_i),
        .is_fill_o (is_fill),
        .is_type_o (is_type),
        .len_ok_o  (len_ok)
    );

    cid_sum8 #(.W(8)) u_sum (
        .acc_i  (ctx_q.sum),
        .add_i  (byte_i),
        .sum_o  (sum_nxt),
        .zero_o (sum_zero)
    );

    cid_watchdog #(.TMO_MS(TMO_MS)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q != ST_IDLE),
        .kick_i   (byte_vld_i || start_i),
        .tick_i   (ms_tick_i),
        .expire_o (expire)
    );

    always_comb begin
        ctx_d         = ctx_q;
        ctx_d.pay_vld = 1'b0;
        ctx_d.ok      = 1'b0;
        ctx_d.err     = 1'b0;
        ctx_d.tmo     = 1'b0;

        if (start_i) begin
            ctx_d.st     = ST_HUNT;
            ctx_d.sum    = '0;
            ctx_d.remain = '0;
            ctx_d.idx    = '0;
        end else if (expire) begin
            ctx_d.st  = ST_IDLE;
            ctx_d.tmo = 1'b1;
        end else if (byte_vld_i) begin
            unique case (ctx_q.st)
                ST_HUNT: begin
                    if (is_type) begin
                        ctx_d.st  = ST_LEN;
                        ctx_d.sum = sum_nxt;
                    end else if (!is_fill) begin
                        ctx_d.st  = ST_IDLE;
                        ctx_d.err = 1'b1;
                    end
                end
                ST_LEN: begin
                    if (len_ok) begin
                        ctx_d.st     = ST_DATA;
                        ctx_d.sum    = sum_nxt;
                        ctx_d.remain = byte_i;
                        ctx_d.idx    = '0;
                    end else begin
                        ctx_d.st  = ST_IDLE;
                        ctx_d.err = 1'b1;
                    end
                end
                ST_DATA: begin
                    ctx_d.pay_vld  = 1'b1;
                    ctx_d.pay_byte = byte_i;
                    ctx_d.pay_idx  = ctx_q.idx;
                    ctx_d.idx      = ctx_q.idx + 8'd1;
                    ctx_d.remain   = ctx_q.remain - 8'd1;
                    ctx_d.sum      = sum_nxt;
                    if (ctx_q.remain == 8'd1) begin
                        ctx_d.st = ST_CSUM;
                    end
                end
                ST_CSUM: begin
                    ctx_d.st  = ST_IDLE;
                    ctx_d.ok  = sum_zero;
                    ctx_d.err = !sum_zero;
                end
                default: begin
                    ctx_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign pay_vld_o  = ctx_q.pay_vld;
    assign pay_byte_o = ctx_q.pay_byte;
    assign pay_idx_o  = ctx_q.pay_idx;
    assign msg_ok_o   = ctx_q.ok;
    assign msg_err_o  = ctx_q.err;
    assign msg_tmo_o  = ctx_q.tmo;
endmodule

// File: rtl/cid_frame_checker_sva.sv
module cid_frame_checker_sva #(
    parameter int unsigned LEN_MIN = 9,
    parameter int unsigned LEN_MAX = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             byte_vld_i,
    input logic [7:0]       byte_i,
    input logic             ms_tick_i,
    input logic             pay_vld_o,
    input logic [7:0]       pay_byte_o,
    input logic [7:0]       pay_idx_o,
    input logic             msg_ok_o,
    input logic             msg_err_o,
    input logic             msg_tmo_o,
    input cid_pkg::state_e  st_q
);
    import cid_pkg::*;

    assert_one_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msg_ok_o, msg_err_o, msg_tmo_o}));

    assert_ok_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ok_o |=> !msg_ok_o);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start_i) |=> (!pay_vld_o && !msg_ok_o && !msg_err_o && !msg_tmo_o));

    assert_bad_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LEN && byte_vld_i && !start_i &&
         (byte_i < 8'(LEN_MIN) || byte_i > 8'(LEN_MAX))) |=> msg_err_o);

    assert_pay_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld_o |-> ($past(byte_vld_i) && $past(byte_i) == pay_byte_o && pay_idx_o < 8'(LEN_MAX)));

    assert_ok_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ok_o |-> ($past(byte_vld_i) && $past(st_q) == ST_CSUM));

    assert_tmo_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_tmo_o |-> ($past(ms_tick_i) && !$past(byte_vld_i) && $past(st_q) != ST_IDLE));
endmodule

bind cid_frame_checker cid_frame_checker_sva #(
    .LEN_MIN (LEN_MIN),
    .LEN_MAX (LEN_MAX)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .ms_tick_i  (ms_tick_i),
    .pay_vld_o  (pay_vld_o),
    .pay_byte_o (pay_byte_o),
    .pay_idx_o  (pay_idx_o),
    .msg_ok_o   (msg_ok_o),
    .msg_err_o  (msg_err_o),
    .msg_tmo_o  (msg_tmo_o),
    .st_q       (st_q)
);

// File: tb/cid_frame_checker_bench.sv
module cid_frame_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       ms_tick_i = 1'b0;
    logic       pay_vld_o;
    logic [7:0] pay_byte_o;
    logic [7:0] pay_idx_o;
    logic       msg_ok_o, msg_err_o, msg_tmo_o;

    cid_frame_checker #(.TMO_MS(TMO)) u_cid_frame_checker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .ms_tick_i(ms_tick_i), .pay_vld_o(pay_vld_o),
        .pay_byte_o(pay_byte_o), .pay_idx_o(pay_idx_o), .msg_ok_o(msg_ok_o),
        .msg_err_o(msg_err_o), .msg_tmo_o(msg_tmo_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    int n_ok = 0, n_err = 0, n_tmo = 0, n_multi = 0, idx_bad = 0, cap_cnt = 0;
    logic [7:0] cap [0:31];
    logic [7:0] dat [0:31];

    always @(negedge clk) begin
        if (rst_n) begin
            if (pay_vld_o) begin
                if (32'(pay_idx_o) != cap_cnt) idx_bad++;
                if (cap_cnt < 32) cap[cap_cnt] = pay_byte_o;
                cap_cnt++;
            end
            if (msg_ok_o) n_ok++;
            if (msg_err_o) n_err++;
            if (msg_tmo_o) n_tmo++;
            if (32'(msg_ok_o) + 32'(msg_err_o) + 32'(msg_tmo_o) > 1) n_multi++;
        end
    end

    task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_ok = 0; n_err = 0; n_tmo = 0; n_multi = 0; idx_bad = 0; cap_cnt = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick_i = 1'b1;
            @(negedge clk) ms_tick_i = 1'b0;
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
        @(negedge clk) byte_vld_i = 1'b0;
    endtask

    task automatic go();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    function automatic logic [7:0] csum_of(input logic [7:0] typ, input logic [7:0] len);
        logic [7:0] s = typ + len;
        for (int i = 0; i < int'(len); i++) s = s + dat[i];
        return 8'(-s);
    endfunction

    task automatic fill_digits(input int len);
        for (int i = 0; i < len; i++) dat[i] = 8'h30 + 8'($urandom % 10);
        if (len > 8 && ($urandom % 2) == 1) begin
            dat[8] = (($urandom % 2) == 1) ? 8'h50 : 8'h4F;
        end
    endtask

    // sends fill, type, length, data, checksum; gap ticks before each byte
    task automatic send_frame(input int nfill, input logic [7:0] len, input logic [7:0] cs, input int gap);
        for (int i = 0; i < nfill; i++) begin tick(gap); put_byte(8'h55); end
        tick(gap); put_byte(8'h04);
        tick(gap); put_byte(len);
        for (int i = 0; i < int'(len); i++) begin tick(gap); put_byte(dat[i]); end
        tick(gap);
        @(negedge clk) begin byte_vld_i = 1'b1; byte_i = cs; end
        @(negedge clk) byte_vld_i = 1'b0;
    endtask

    task automatic check_frame(input string req, input int len, input bit exp_ok);
        int mism = 0;
        idle(2);
        for (int i = 0; i < len && i < 32; i++) if (cap[i] !== dat[i]) mism++;
        chk(n_ok == int'(exp_ok), req, "good pulses", n_ok, int'(exp_ok));
        chk(n_err == int'(!exp_ok), req, "error pulses", n_err, int'(!exp_ok));
        chk(cap_cnt == len && mism == 0 && idx_bad == 0, "R5", "payload count", cap_cnt, len);
        chk(n_tmo == 0 && n_multi == 0, "R8", "stray pulses", n_tmo + n_multi, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] cs;
        void'($urandom(32'd20240611));
        idle(3);
        // R1: outputs low in reset
        chk({pay_vld_o, msg_ok_o, msg_err_o, msg_tmo_o} == 4'b0, "R1", "outputs in reset",
            int'({pay_vld_o, msg_ok_o, msg_err_o, msg_tmo_o}), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk({pay_vld_o, msg_ok_o, msg_err_o, msg_tmo_o} == 4'b0, "R1", "outputs after reset",
            int'({pay_vld_o, msg_ok_o, msg_err_o, msg_tmo_o}), 0);

        // R2: bytes and ticks while idle do nothing
        clear_mon();
        fill_digits(10);
        send_frame(0, 8'd10, csum_of(8'h04, 8'd10), 0);
        tick(TMO + 2);
        idle(2);
        chk(cap_cnt == 0 && n_ok + n_err + n_tmo == 0, "R2", "activity while idle",
            cap_cnt + n_ok + n_err + n_tmo, 0);

        // R3/R6/R9: good frame with fill, max length, result one cycle after checksum
        clear_mon();
        go();
        fill_digits(18);
        send_frame(3, 8'd18, csum_of(8'h04, 8'd18), 1);
        chk(msg_ok_o == 1'b1, "R9", "good pulse one cycle after checksum", int'(msg_ok_o), 1);
        check_frame("R6", 18, 1'b1);

        // R4: shortest length accepted
        clear_mon();
        go();
        fill_digits(9);
        send_frame(0, 8'd9, csum_of(8'h04, 8'd9), 0);
        check_frame("R4", 9, 1'b1);

        // R4: length 8 and 19 rejected; later bytes ignored (R2)
        foreach (dat[i]) dat[i] = 8'h31;
        for (int k = 0; k < 2; k++) begin
            logic [7:0] bad = (k == 0) ? 8'd8 : 8'd19;
            clear_mon();
            go();
            put_byte(8'h04);
            put_byte(bad);
            chk(msg_err_o == 1'b1, "R4", "error pulse on bad length", int'(msg_err_o), 1);
            for (int i = 0; i < 10; i++) put_byte(8'h31);
            idle(2);
            chk(n_err == 1 && cap_cnt == 0 && n_ok == 0, "R2", "bytes after bad length",
                cap_cnt + n_ok, 0);
        end

        // R3: wrong type
        clear_mon();
        go();
        put_byte(8'h55);
        put_byte(8'h80);
        idle(2);
        chk(n_err == 1 && n_ok == 0, "R3", "error pulses on bad type", n_err, 1);

        // R6: bad checksum
        clear_mon();
        go();
        fill_digits(12);
        send_frame(1, 8'd12, csum_of(8'h04, 8'd12) + 8'd1, 0);
        chk(msg_err_o == 1'b1, "R9", "error pulse one cycle after checksum", int'(msg_err_o), 1);
        check_frame("R6", 12, 1'b0);

        // R5: fill value inside the data is data
        clear_mon();
        go();
        foreach (dat[i]) dat[i] = 8'h55;
        send_frame(2, 8'd11, csum_of(8'h04, 8'd11), 0);
        check_frame("R5", 11, 1'b1);

        // R7: timeout while hunting, then stream ignored
        clear_mon();
        go();
        tick(TMO);
        idle(2);
        chk(n_tmo == 1 && n_err == 0, "R7", "timeout in hunt", n_tmo, 1);
        fill_digits(10);
        send_frame(0, 8'd10, csum_of(8'h04, 8'd10), 0);
        idle(2);
        chk(n_ok == 0 && cap_cnt == 0, "R2", "stream after timeout", n_ok + cap_cnt, 0);

        // R7: gaps one tick short never time out
        clear_mon();
        go();
        fill_digits(14);
        send_frame(1, 8'd14, csum_of(8'h04, 8'd14), TMO - 1);
        check_frame("R7", 14, 1'b1);

        // R7: timeout in the middle of the data
        clear_mon();
        go();
        fill_digits(10);
        put_byte(8'h04); put_byte(8'd10);
        for (int i = 0; i < 4; i++) put_byte(dat[i]);
        tick(TMO);
        idle(2);
        chk(n_tmo == 1 && n_ok + n_err == 0 && cap_cnt == 4, "R7", "timeout mid data", n_tmo, 1);

        // R7: tick together with a byte counts as a byte
        clear_mon();
        go();
        fill_digits(9);
        cs = csum_of(8'h04, 8'd9);
        put_byte(8'h04);
        tick(TMO - 1);
        @(negedge clk) begin byte_vld_i = 1'b1; byte_i = 8'd9; ms_tick_i = 1'b1; end
        @(negedge clk) begin byte_vld_i = 1'b0; ms_tick_i = 1'b0; end
        tick(TMO - 1);
        for (int i = 0; i < 9; i++) put_byte(dat[i]);
        put_byte(cs);
        check_frame("R7", 9, 1'b1);

        // R2: restart mid frame
        clear_mon();
        go();
        put_byte(8'h04); put_byte(8'd12); put_byte(8'h33);
        go();
        fill_digits(10);
        send_frame(0, 8'd10, csum_of(8'h04, 8'd10), 0);
        idle(2);
        chk(n_ok == 1 && n_err == 0 && cap_cnt == 11, "R2", "restart drops partial frame", n_ok, 1);

        // random frames
        for (int f = 0; f < 60; f++) begin
            int len = 9 + int'($urandom % 10);
            int gap = int'($urandom % TMO);
            bit corrupt = ($urandom % 2) == 1;
            clear_mon();
            go();
            fill_digits(len);
            cs = csum_of(8'h04, 8'(len));
            if (corrupt) cs = cs + 8'(1 + ($urandom % 255));
            send_frame(int'($urandom % 5), 8'(len), cs, gap);
            check_frame("R6", len, !corrupt);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule